// File: doc/BRIEF.md
# SMBus Special-Address Acknowledge Logic

This block sits in the address phase of a slave serial-bus controller. The shift logic delivers a 7-bit received address together with a one-cycle valid strobe. From that address the block decides whether the controller should acknowledge it. It always compares the address against the device's own programmed slot addresses. When SMBus mode is switched on, it can also accept three reserved SMBus addresses: the alert response address, the host header and the device default address. Each of these is gated by its own configuration bits.

The acknowledge decision is combinational, so it is ready in the same cycle as the strobe. The block also reports which kind of address matched as a small code. That code is captured on the strobe and held for software until the next start condition clears it. Serial shifting, clock stretching and data movement belong to neighbouring logic.

Top module: `smbus_addr_ack`

## Requirements
- R1: With `own_en[k]` set, an address equal to own slot k (bits `[7k+6:7k]` of `own_addr`) is acknowledged whatever the SMBus settings, reporting match code 1 (OWN).
- R2: An own slot whose `own_en` bit is clear never causes an acknowledge.
- R3: Address 7'b1100001 is acknowledged with code 4 (DEVDEF) only when `smbus_en`=1, `arp_en`=1 and `dev_is_host`=0.
- R4: Address 7'b0001000 is acknowledged with code 3 (HOST) only when `smbus_en`=1, `arp_en`=1 and `dev_is_host`=1.
- R5: Address 7'b0001100 is acknowledged with code 2 (ALERT) whenever `smbus_en`=1 and `alert_en`=1, independent of `arp_en`.
- R6: With `smbus_en`=0 none of the three reserved addresses is acknowledged unless it equals an enabled own slot.
- R7: `addr_ack` is high only in a cycle where `addr_valid` is high; the decision appears combinationally in that cycle.
- R8: When several sources match, the reported code follows the priority OWN(1) > ALERT(2) > HOST(3) > DEVDEF(4); a non-acknowledged address reports 0 (NONE).
- R9: `match_type` loads the code of the strobed address at the clock edge that samples `addr_valid`. It then holds until an edge that samples `start_det`, which clears it to 0. If both are high at the same edge, the load wins.
- R10: A synchronous active-low reset forces `match_type` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_addr | input | 7 | Received 7-bit address, R/W bit already removed |
| addr_valid | input | 1 | One-cycle strobe marking `rx_addr` as complete |
| start_det | input | 1 | Start condition seen on the bus |
| own_addr | input | 14 | Own slot addresses, slot k in bits [7k+6:7k] |
| own_en | input | 2 | Per-slot enable for the own addresses |
| smbus_en | input | 1 | Enables reserved SMBus address matching |
| dev_is_host | input | 1 | 0 = device role, 1 = host role |
| arp_en | input | 1 | Address resolution enable |
| alert_en | input | 1 | Alert response enable |
| addr_ack | output | 1 | Acknowledge decision for the strobed address |
| match_type | output | 3 | Latched match code: 0 NONE, 1 OWN, 2 ALERT, 3 HOST, 4 DEVDEF |

## Verification
The bench tries each reserved address under every nearby setting of the type, resolution and alert bits. A swapped or dropped gating term would therefore acknowledge a reserved address in the wrong role, or when SMBus mode is off. It programs an own slot onto a reserved address to expose a priority encoder that ranks the reserved matches above the own address. It raises a start and a strobe together, and checks that the code holds across idle cycles. A register that clears on the wrong input, or that lets the start win, shows up as a lost or stale code. It also presents a matching address without the strobe, which catches an acknowledge that is not gated by the strobe.

// File: rtl/smbus_ack_pkg.sv
// Shared constants and types for the SMBus address acknowledge block.
// Assumes 7-bit addressing; the reserved addresses are fixed bus values.
package smbus_ack_pkg;

    localparam int ADDR_W   = 7;
    localparam int NUM_RSVD = 3;
    localparam int CODE_W   = 3;

    typedef logic [ADDR_W-1:0] addr_t;

    // Index order of the reserved table is also the priority order among them.
    localparam int IDX_ALERT  = 0;
    localparam int IDX_HOST   = 1;
    localparam int IDX_DEVDEF = 2;

    localparam addr_t RSVD_ADDR [NUM_RSVD] = '{
        7'b0001100,   // alert response
        7'b0001000,   // host header
        7'b1100001    // device default
    };

    typedef enum logic [CODE_W-1:0] {
        MT_NONE   = 3'd0,
        MT_OWN    = 3'd1,
        MT_ALERT  = 3'd2,
        MT_HOST   = 3'd3,
        MT_DEVDEF = 3'd4
    } match_t;

endpackage

// File: rtl/smbus_own_match.sv
// Compares the received address against every enabled own slot.
// Assumes slots are packed back to back, slot k at [k*ADDR_W +: ADDR_W].
module smbus_own_match
    import smbus_ack_pkg::*;
#(
    parameter int NUM_OWN = 2
) (
    input  logic [ADDR_W-1:0]         rx_addr,
    input  logic [NUM_OWN*ADDR_W-1:0] own_addr,
    input  logic [NUM_OWN-1:0]        own_en,
    output logic                      own_hit
);

    logic [NUM_OWN-1:0] slot_hit;

    // One comparator per slot, gated by that slot's enable.
    for (genvar k = 0; k < NUM_OWN; k++) begin : g_slot
        assign slot_hit[k] = own_en[k] && (rx_addr == own_addr[k*ADDR_W +: ADDR_W]);
    end

    // Any enabled slot matching counts as an own-address hit.
    assign own_hit = |slot_hit;

endmodule

// File: rtl/smbus_rsvd_match.sv
// Matches the received address against the reserved SMBus addresses.
// Each entry has its own qualifier built from the mode and role bits;
// all qualifiers are forced low while SMBus mode is off.
module smbus_rsvd_match
    import smbus_ack_pkg::*;
(
    input  logic [ADDR_W-1:0]   rx_addr,
    input  logic                smbus_en,
    input  logic                dev_is_host,
    input  logic                arp_en,
    input  logic                alert_en,
    output logic [NUM_RSVD-1:0] rsvd_hit
);

    logic [NUM_RSVD-1:0] rsvd_allow;

    // Qualifiers per reserved entry, derived from the configuration bits.
    always_comb begin
        rsvd_allow             = '0;
        rsvd_allow[IDX_ALERT]  = smbus_en && alert_en;
        rsvd_allow[IDX_HOST]   = smbus_en && arp_en &&  dev_is_host;
        rsvd_allow[IDX_DEVDEF] = smbus_en && arp_en && !dev_is_host;
    end

    // One constant comparator per reserved address.
    for (genvar i = 0; i < NUM_RSVD; i++) begin : g_rsvd
        assign rsvd_hit[i] = rsvd_allow[i] && (rx_addr == RSVD_ADDR[i]);
    end

endmodule

// File: rtl/smbus_match_reg.sv
// Priority-encodes the match sources and holds the resulting code.
// Assumes addr_valid is a single-cycle strobe; a strobe at the same edge
// as a start condition takes precedence over the clear.
module smbus_match_reg
    import smbus_ack_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_valid,
    input  logic                start_det,
    input  logic                own_hit,
    input  logic [NUM_RSVD-1:0] rsvd_hit,
    output logic                any_hit,
    output match_t              match_q
);

    match_t code_next;

    // Fixed priority: own, then reserved entries in table order.
    always_comb begin
        if (own_hit)                   code_next = MT_OWN;
        else if (rsvd_hit[IDX_ALERT])  code_next = MT_ALERT;
        else if (rsvd_hit[IDX_HOST])   code_next = MT_HOST;
        else if (rsvd_hit[IDX_DEVDEF]) code_next = MT_DEVDEF;
        else                           code_next = MT_NONE;
    end

    assign any_hit = (code_next != MT_NONE);

    // Capture on the strobe, clear on start, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          match_q <= MT_NONE;
        else if (addr_valid) match_q <= code_next;
        else if (start_det)  match_q <= MT_NONE;
    end

endmodule

// File: rtl/smbus_addr_ack.sv
// Top of the SMBus address acknowledge block: own-slot matching, reserved
// address matching, acknowledge decision and latched match code.
// Assumes rx_addr is stable whenever addr_valid is high.
module smbus_addr_ack
    import smbus_ack_pkg::*;
#(
    parameter int NUM_OWN = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         rx_addr,
    input  logic                      addr_valid,
    input  logic                      start_det,
    input  logic [NUM_OWN*ADDR_W-1:0] own_addr,
    input  logic [NUM_OWN-1:0]        own_en,
    input  logic                      smbus_en,
    input  logic                      dev_is_host,
    input  logic                      arp_en,
    input  logic                      alert_en,
    output logic                      addr_ack,
    output logic [CODE_W-1:0]         match_type
);

    logic                own_hit;
    logic [NUM_RSVD-1:0] rsvd_hit;
    logic                any_hit;
    match_t              match_q;

    smbus_own_match #(.NUM_OWN(NUM_OWN)) u_own (
        .rx_addr (rx_addr),
        .own_addr(own_addr),
        .own_en  (own_en),
        .own_hit (own_hit)
    );

    smbus_rsvd_match u_rsvd (
        .rx_addr    (rx_addr),
        .smbus_en   (smbus_en),
        .dev_is_host(dev_is_host),
        .arp_en     (arp_en),
        .alert_en   (alert_en),
        .rsvd_hit   (rsvd_hit)
    );

    smbus_match_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_valid(addr_valid),
        .start_det (start_det),
        .own_hit   (own_hit),
        .rsvd_hit  (rsvd_hit),
        .any_hit   (any_hit),
        .match_q   (match_q)
    );

    // Acknowledge only in the strobe cycle.
    assign addr_ack   = addr_valid && any_hit;
    assign match_type = match_q;

endmodule

// File: rtl/smbus_addr_ack_chk.sv
// Port-level properties for smbus_addr_ack, attached with bind below.
module smbus_addr_ack_chk
    import smbus_ack_pkg::*;
#(
    parameter int NUM_OWN = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         rx_addr,
    input logic                      addr_valid,
    input logic                      start_det,
    input logic [NUM_OWN*ADDR_W-1:0] own_addr,
    input logic [NUM_OWN-1:0]        own_en,
    input logic                      smbus_en,
    input logic                      addr_ack,
    input logic [CODE_W-1:0]         match_type
);

    logic own_any;
    always_comb begin
        own_any = 1'b0;
        for (int k = 0; k < NUM_OWN; k++)
            if (own_en[k] && rx_addr == own_addr[k*ADDR_W +: ADDR_W]) own_any = 1'b1;
    end

    // R7: no acknowledge outside the strobe cycle
    p_ack_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> addr_valid);

    // R6: with SMBus mode off only an own slot may be acknowledged
    p_plain_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && !smbus_en) |-> own_any);

    // R1: an enabled own slot is always acknowledged with the OWN code
    p_own_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && own_any) |=> (match_type == 3'd1));

    // R9: acknowledged strobe leaves a non-zero code
    p_load_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ack) |=> (match_type != 3'd0));

    // R8: rejected strobe leaves NONE
    p_load_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ack) |=> (match_type == 3'd0));

    // R9: code held while idle
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !start_det) |=> $stable(match_type));

    // R9: start without strobe clears the code
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !addr_valid) |=> (match_type == 3'd0));

endmodule

bind smbus_addr_ack smbus_addr_ack_chk #(.NUM_OWN(NUM_OWN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_addr   (rx_addr),
    .addr_valid(addr_valid),
    .start_det (start_det),
    .own_addr  (own_addr),
    .own_en    (own_en),
    .smbus_en  (smbus_en),
    .addr_ack  (addr_ack),
    .match_type(match_type)
);

// File: tb/sim_smbus_addr_ack.sv
module sim_smbus_addr_ack;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  rx_addr;
    logic        addr_valid, start_det;
    logic [13:0] own_addr;
    logic [1:0]  own_en;
    logic        smbus_en, dev_is_host, arp_en, alert_en;
    logic        addr_ack;
    logic [2:0]  match_type;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_addr_ack u0 (
        .clk(clk), .rst_n(rst_n), .rx_addr(rx_addr), .addr_valid(addr_valid),
        .start_det(start_det), .own_addr(own_addr), .own_en(own_en),
        .smbus_en(smbus_en), .dev_is_host(dev_is_host), .arp_en(arp_en),
        .alert_en(alert_en), .addr_ack(addr_ack), .match_type(match_type)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [6:0] a;
        logic       sm, arp, host, al;
        logic [6:0] o0, o1;
        logic [1:0] oen;
        logic       eack;
        logic [2:0] ecode;
    } vec_t;

    // {req, addr, smbus, arp, host, alert, own0, own1, own_en, ack, code}
    localparam logic [35:0] TBL [NVEC] = '{
        {4'd1,  7'h2A, 4'b0000, 7'h2A, 7'h55, 2'b01, 1'b1, 3'd1}, // R1 plain mode
        {4'd1,  7'h2A, 4'b1111, 7'h2A, 7'h55, 2'b01, 1'b1, 3'd1}, // R1 all smbus bits
        {4'd2,  7'h55, 4'b0000, 7'h2A, 7'h55, 2'b01, 1'b0, 3'd0}, // R2 slot disabled
        {4'd2,  7'h55, 4'b0000, 7'h2A, 7'h55, 2'b11, 1'b1, 3'd1}, // R2 slot enabled
        {4'd3,  7'h61, 4'b1100, 7'h2A, 7'h55, 2'b01, 1'b1, 3'd4}, // R3 device default
        {4'd3,  7'h61, 4'b1110, 7'h2A, 7'h55, 2'b01, 1'b0, 3'd0}, // R3 host role
        {4'd3,  7'h61, 4'b1001, 7'h2A, 7'h55, 2'b01, 1'b0, 3'd0}, // R3 arp off
        {4'd4,  7'h08, 4'b1110, 7'h2A, 7'h55, 2'b01, 1'b1, 3'd3}, // R4 host header
        {4'd4,  7'h08, 4'b1100, 7'h2A, 7'h55, 2'b01, 1'b0, 3'd0}, // R4 device role
        {4'd5,  7'h0C, 4'b1001, 7'h2A, 7'h55, 2'b01, 1'b1, 3'd2}, // R5 alert, arp off
        {4'd5,  7'h0C, 4'b1110, 7'h2A, 7'h55, 2'b01, 1'b0, 3'd0}, // R5 alert off
        {4'd6,  7'h0C, 4'b0111, 7'h2A, 7'h55, 2'b01, 1'b0, 3'd0}, // R6 smbus off
        {4'd6,  7'h61, 4'b0100, 7'h2A, 7'h55, 2'b01, 1'b0, 3'd0}, // R6 smbus off
        {4'd8,  7'h0C, 4'b1001, 7'h0C, 7'h55, 2'b01, 1'b1, 3'd1}, // R8 own over alert
        {4'd8,  7'h08, 4'b1110, 7'h2A, 7'h08, 2'b10, 1'b1, 3'd1}  // R8 own over host
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a strobed address; check ack in-cycle and code after the edge.
    task automatic strobe(input string req, input logic eack, input logic [2:0] ecode);
        addr_valid = 1'b1;
        #2;
        check(req, {2'b0, addr_ack}, {2'b0, eack});
        @(negedge clk);
        addr_valid = 1'b0;
        #1;
        check(req, match_type, ecode);
    endtask

    initial begin
        #(CLK_PERIOD*2000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_addr = '0; addr_valid = 1'b0; start_det = 1'b0;
        own_addr = {7'h55, 7'h2A}; own_en = 2'b01;
        smbus_en = 1'b0; dev_is_host = 1'b0; arp_en = 1'b0; alert_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R10", match_type, 3'd0);
        check("R10", {2'b0, addr_ack}, 3'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            @(negedge clk);
            v = vec_t'(TBL[i]);
            rx_addr = v.a; smbus_en = v.sm; arp_en = v.arp;
            dev_is_host = v.host; alert_en = v.al;
            own_addr = {v.o1, v.o0}; own_en = v.oen;
            strobe($sformatf("R%0d vec%0d", v.req, i), v.eack, v.ecode);
        end

        // R7: matching address without strobe gives no ack
        @(negedge clk);
        own_addr = {7'h55, 7'h2A}; own_en = 2'b01;
        smbus_en = 1'b1; arp_en = 1'b1; dev_is_host = 1'b1; alert_en = 1'b1;
        rx_addr = 7'h2A;
        #2;
        check("R7", {2'b0, addr_ack}, 3'd0);

        // R9: load HOST, hold for several cycles
        @(negedge clk);
        rx_addr = 7'h08;
        strobe("R9 load", 1'b1, 3'd3);
        rx_addr = 7'h00;
        repeat (4) @(negedge clk);
        #1;
        check("R9 hold", match_type, 3'd3);

        // R9: start clears
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        #1;
        check("R9 clear", match_type, 3'd0);

        // R9: start and strobe together, load wins
        @(negedge clk);
        rx_addr = 7'h0C; start_det = 1'b1;
        strobe("R9 both", 1'b1, 3'd2);
        start_det = 1'b0;

        // R10: reset clears a held code
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R10 reset", match_type, 3'd0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule